// File: doc/BRIEF.md
# Power-Fail Access Guard

This block sits between a host bus and a battery-backed clock/RAM store and decides, from two digital supply flags, whether the store may be touched. One flag says the main supply is above the write-protect level. The other says it is above the battery-switch level. Both flags come from asynchronous comparators and are resynchronised before use.

While the supply is low, or during a fixed recovery interval after it returns, the guard refuses new bus cycles and drives an active-low reset. It also aborts any cycle that is already in flight, so a half-finished write is never committed.

The guard reports the present power mode and selects the backup battery only once the battery has been armed. Arming happens on the first valid power-up. Switchover to the battery happens only when the supply is below both thresholds, which is the lower of the two levels.

Requests use a valid/ready handshake. A request is taken on a clock edge where `req_valid` and `req_ready` are both high. Address, data and direction are captured on that edge. `req_ready` is low while a cycle is running and whenever protection is active. The requester may hold or drop `req_valid` at any time; nothing is taken while ready is low.

Top module: `pwr_access_guard`

## Requirements
- R1: Each supply flag passes through two flip-flops, so an input change first shows in `pwr_mode` and `rst_out_n` two clock edges later.
- R2: While protection is active (write-protect flag low, or recovery pending), `req_ready` is 0 and no request is accepted.
- R3: `rst_out_n` goes 0 two edges after the write-protect flag falls. After the flag rises, `rst_out_n` returns to 1 exactly 2 + REC_CYCLES edges after the input change.
- R4: The battery-arm latch is 0 after reset, sets once the synchronised write-protect flag is seen high, and then stays set until the next reset.
- R5: `bat_sel` is 1 only when the battery is armed and both synchronised flags are low. With write-protect high and battery-switch low, `bat_sel` stays 0.
- R6: `pwr_mode` encodes the power mode as follows:
  - 0 = active: write-protect flag high.
  - 1 = standby: write-protect flag low, battery-switch flag high.
  - 2 = retention: both flags low, battery armed.
  - 3 = unpowered: both flags low, battery not armed.
- R7: An accepted cycle completes CYC_LEN edges after acceptance. On completion, `cyc_done` pulses for one cycle, and `mem_we` pulses in the same cycle only for a write.
- R8: When protection becomes active during a running cycle, the cycle ends on the next edge: `cyc_abort` pulses for one cycle, and neither `mem_we` nor `cyc_done` pulses for that cycle.
- R9: `req_ready` is 0 while a cycle is running. `mem_addr` and `mem_wdata` hold the values captured on the accepting edge.
- R10: After reset the outputs are: `rst_out_n` = 0, `req_ready` = 0, `bat_sel` = 0, `pwr_mode` = 3, `mem_we` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset; also disarms the battery |
| vcc_wp_ok | input | 1 | Asynchronous flag: supply above write-protect level |
| vcc_bs_ok | input | 1 | Asynchronous flag: supply above battery-switch level |
| req_valid | input | 1 | Bus request valid |
| req_ready | output | 1 | Guard can accept a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Request address |
| req_wdata | input | DATA_W | Write data |
| mem_addr | output | ADDR_W | Captured address of the current or last cycle |
| mem_wdata | output | DATA_W | Captured write data |
| mem_we | output | 1 | One-cycle write commit strobe |
| cyc_done | output | 1 | One-cycle pulse when a cycle completes |
| cyc_abort | output | 1 | One-cycle pulse when a cycle is aborted |
| rst_out_n | output | 1 | Active-low reset to the system |
| bat_sel | output | 1 | 1 = backup battery powers the store |
| pwr_mode | output | 2 | Power mode, encoded per R6 |

## Verification
The assertions check, on every cycle, the properties that hold cycle by cycle:
- the arm latch never clears;
- the battery is never selected unarmed;
- no commit follows a protected cycle;
- a running cycle ends the edge after protection;
- reset release always follows a supply that was already good.

The exact latencies need the bench's scenarios:
- the two-edge synchroniser delay;
- the 2 + REC_CYCLES release point;
- the CYC_LEN completion time.

The bench's scenarios also cover the full mode table across threshold orderings, and the abort of an in-flight write when power drops.

// File: rtl/pwr_guard_pkg.sv
package pwr_guard_pkg;
  typedef enum logic [1:0] {
    PM_ACTIVE    = 2'd0,
    PM_STANDBY   = 2'd1,
    PM_RETAIN    = 2'd2,
    PM_UNPOWERED = 2'd3
  } pwr_mode_e;
endpackage

// File: rtl/pwr_flag_sync.sv
module pwr_flag_sync #(
  parameter int WIDTH = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] async_i,
  output logic [WIDTH-1:0] sync_o
);
  // Two-stage synchroniser, one chain per flag (R1)
  for (genvar g = 0; g < WIDTH; g++) begin : g_chain
    logic meta_q, sync_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        meta_q <= 1'b0;
        sync_q <= 1'b0;
      end else begin
        meta_q <= async_i[g];
        sync_q <= meta_q;
      end
    end
    assign sync_o[g] = sync_q;
  end
endmodule

// File: rtl/pwr_supply_sel.sv
module pwr_supply_sel
  import pwr_guard_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wp_ok_i,
  input  logic       bs_ok_i,
  output logic       bat_sel_o,
  output logic [1:0] mode_o
);
  logic      armed_q;
  pwr_mode_e mode;

  // Battery arm latch, set on first valid power-up (R4)
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       armed_q <= 1'b0;
    else if (wp_ok_i) armed_q <= 1'b1;
  end

  always_comb begin
    if (wp_ok_i)      mode = PM_ACTIVE;
    else if (bs_ok_i) mode = PM_STANDBY;
    else if (armed_q) mode = PM_RETAIN;
    else              mode = PM_UNPOWERED;
  end

  assign mode_o    = mode;
  assign bat_sel_o = (mode == PM_RETAIN);

  a_r4_arm_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    $past(armed_q) |-> armed_q);
  a_r5_bat_needs_arm: assert property (@(posedge clk) disable iff (!rst_n)
    bat_sel_o |-> armed_q && !$past(bat_sel_o && wp_ok_i));
endmodule

// File: rtl/pwr_recovery.sv
module pwr_recovery #(
  parameter int REC_CYCLES = 1_750_000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic wp_ok_i,
  output logic prot_o
);
  localparam int CW = $clog2(REC_CYCLES + 1) < 1 ? 1 : $clog2(REC_CYCLES + 1);
  localparam logic [CW-1:0] REC_LOAD = CW'(REC_CYCLES);

  logic [CW-1:0] cnt_q;

  // Recovery countdown restarts whenever supply is below write-protect (R3)
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             cnt_q <= REC_LOAD;
    else if (!wp_ok_i)      cnt_q <= REC_LOAD;
    else if (cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
  end

  assign prot_o = !wp_ok_i || (cnt_q != '0);

  a_r3_release_after_good: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(prot_o) |-> (REC_CYCLES == 0) || $past(wp_ok_i));
endmodule

// File: rtl/pwr_bus_gate.sv
module pwr_bus_gate #(
  parameter int ADDR_W  = 15,
  parameter int DATA_W  = 8,
  parameter int CYC_LEN = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              prot_i,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  output logic              mem_we,
  output logic              cyc_done,
  output logic              cyc_abort
);
  localparam int CNT_W = $clog2(CYC_LEN + 1);
  localparam logic [CNT_W-1:0] LEN_M1 = CNT_W'(CYC_LEN - 1);

  logic             busy_q, wr_q;
  logic [CNT_W-1:0] cnt_q;

  assign req_ready = !busy_q && !prot_i;   // R2, R9

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q    <= 1'b0;
      wr_q      <= 1'b0;
      cnt_q     <= '0;
      mem_addr  <= '0;
      mem_wdata <= '0;
      mem_we    <= 1'b0;
      cyc_done  <= 1'b0;
      cyc_abort <= 1'b0;
    end else begin
      mem_we    <= 1'b0;
      cyc_done  <= 1'b0;
      cyc_abort <= 1'b0;
      if (busy_q) begin
        if (prot_i) begin              // R8 abort, nothing committed
          busy_q    <= 1'b0;
          cyc_abort <= 1'b1;
        end else if (cnt_q == '0) begin // R7 completion
          busy_q   <= 1'b0;
          cyc_done <= 1'b1;
          mem_we   <= wr_q;
        end else begin
          cnt_q <= cnt_q - 1'b1;
        end
      end else if (req_valid && req_ready) begin
        busy_q    <= 1'b1;
        cnt_q     <= LEN_M1;
        wr_q      <= req_write;
        mem_addr  <= req_addr;
        mem_wdata <= req_wdata;
      end
    end
  end

  a_r8_no_commit_when_prot: assert property (@(posedge clk) disable iff (!rst_n)
    $past(prot_i) |-> !mem_we && !cyc_done);
  a_r8_abort_next_edge: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && prot_i) |=> !busy_q && cyc_abort);
  a_r7_one_outcome: assert property (@(posedge clk) disable iff (!rst_n)
    !(cyc_done && cyc_abort));
endmodule

// File: rtl/pwr_access_guard.sv
module pwr_access_guard #(
  parameter int ADDR_W     = 15,
  parameter int DATA_W     = 8,
  parameter int CYC_LEN    = 4,
  parameter int REC_CYCLES = 1_750_000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              vcc_wp_ok,
  input  logic              vcc_bs_ok,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  output logic              mem_we,
  output logic              cyc_done,
  output logic              cyc_abort,
  output logic              rst_out_n,
  output logic              bat_sel,
  output logic [1:0]        pwr_mode
);
  logic [1:0] flags_s;
  logic       prot;

  pwr_flag_sync #(.WIDTH(2)) u_sync (
    .clk(clk), .rst_n(rst_n),
    .async_i({vcc_bs_ok, vcc_wp_ok}), .sync_o(flags_s)
  );

  pwr_recovery #(.REC_CYCLES(REC_CYCLES)) u_rec (
    .clk(clk), .rst_n(rst_n), .wp_ok_i(flags_s[0]), .prot_o(prot)
  );

  pwr_supply_sel u_sup (
    .clk(clk), .rst_n(rst_n), .wp_ok_i(flags_s[0]), .bs_ok_i(flags_s[1]),
    .bat_sel_o(bat_sel), .mode_o(pwr_mode)
  );

  pwr_bus_gate #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .CYC_LEN(CYC_LEN)) u_bus (
    .clk(clk), .rst_n(rst_n), .prot_i(prot),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_we(mem_we),
    .cyc_done(cyc_done), .cyc_abort(cyc_abort)
  );

  assign rst_out_n = !prot;

  a_r2_no_ready_in_reset: assert property (@(posedge clk) disable iff (!rst_n)
    !rst_out_n |-> !req_ready);
  a_r5_no_battery_with_ready: assert property (@(posedge clk) disable iff (!rst_n)
    bat_sel |-> !rst_out_n);
endmodule

// File: tb/pwr_access_guard_test.sv
module pwr_access_guard_test;
  localparam int ADDR_W = 15, DATA_W = 8, CYC_LEN = 4, REC = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic vcc_wp_ok = 1'b0, vcc_bs_ok = 1'b0;
  logic req_valid = 1'b0, req_write = 1'b0;
  logic [ADDR_W-1:0] req_addr = '0;
  logic [DATA_W-1:0] req_wdata = '0;
  logic req_ready, mem_we, cyc_done, cyc_abort, rst_out_n, bat_sel;
  logic [ADDR_W-1:0] mem_addr;
  logic [DATA_W-1:0] mem_wdata;
  logic [1:0] pwr_mode;

  int nchk = 0, nfail = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  pwr_access_guard #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .CYC_LEN(CYC_LEN),
                     .REC_CYCLES(REC)) uut (.*);

  task automatic chk(input string req, input int act, input int exp);
    nchk++;
    if (act != exp) begin
      nfail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic edges(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  // {wp, bs, expected mode, expected bat_sel}, applied after arming
  localparam logic [4:0] VEC [6] = '{
    {1'b0, 1'b0, 2'd2, 1'b1},
    {1'b1, 1'b0, 2'd0, 1'b0},
    {1'b0, 1'b1, 2'd1, 1'b0},
    {1'b0, 1'b0, 2'd2, 1'b1},
    {1'b1, 1'b1, 2'd0, 1'b0},
    {1'b1, 1'b0, 2'd0, 1'b0}
  };

  task automatic bus_cycle(input logic wr, input int addr, input int data);
    chk("R9 ready before", req_ready, 1);
    req_valid = 1; req_write = wr; req_addr = ADDR_W'(addr); req_wdata = DATA_W'(data);
    edges(1);
    req_valid = 0;
    chk("R9 busy ready", req_ready, 0);
    chk("R9 addr", mem_addr, addr);
    chk("R9 data", mem_wdata, data);
    edges(CYC_LEN - 1);
    chk("R7 no early done", cyc_done, 0);
    edges(1);
    chk("R7 done", cyc_done, 1);
    chk("R7 we", mem_we, wr);
    edges(1);
    chk("R7 pulse ends", cyc_done | mem_we, 0);
  endtask

  initial begin
    edges(3);
    rst_n = 1;
    edges(1);
    chk("R10 rst_out_n", rst_out_n, 0);
    chk("R10 ready", req_ready, 0);
    chk("R10 bat_sel", bat_sel, 0);
    chk("R10 mode", pwr_mode, 3);
    chk("R10 we", mem_we, 0);

    // power-up with a request pending: R1, R2, R3
    vcc_wp_ok = 1; vcc_bs_ok = 1; req_valid = 1; req_write = 1;
    edges(1);
    chk("R1 mode after one edge", pwr_mode, 3);
    edges(1);
    chk("R1 mode after two edges", pwr_mode, 0);
    chk("R2 ready in recovery", req_ready, 0);
    edges(REC - 1);
    chk("R3 still in reset", rst_out_n, 0);
    chk("R2 nothing accepted", cyc_done | mem_we, 0);
    req_valid = 0;
    edges(1);
    chk("R3 released", rst_out_n, 1);

    bus_cycle(1'b1, 15'h7ff8, 8'hA5);
    bus_cycle(1'b0, 15'h0123, 8'h00);

    // abort of a running write: R8, R3 drop, R6 standby
    req_valid = 1; req_write = 1; req_addr = 15'h10; req_wdata = 8'h3c;
    edges(1);
    req_valid = 0; vcc_wp_ok = 0;
    edges(1);
    chk("R3 reset not yet", rst_out_n, 1);
    chk("R8 no abort yet", cyc_abort, 0);
    edges(1);
    chk("R3 reset on drop", rst_out_n, 0);
    chk("R6 standby", pwr_mode, 1);
    chk("R8 no we", mem_we, 0);
    edges(1);
    chk("R8 abort", cyc_abort, 1);
    chk("R8 no we at abort", mem_we, 0);
    edges(1);
    chk("R8 no late commit", mem_we | cyc_done, 0);

    // mode table: R4, R5, R6
    foreach (VEC[i]) begin
      vcc_wp_ok = VEC[i][4]; vcc_bs_ok = VEC[i][3];
      edges(2);
      chk("R6 mode table", pwr_mode, VEC[i][2:1]);
      chk("R5 bat_sel table", bat_sel, VEC[i][0]);
    end

    edges(REC + 2);
    bus_cycle(1'b1, 15'h0042, 8'h99);

    // reset disarms battery: R4
    rst_n = 0; vcc_wp_ok = 0; vcc_bs_ok = 0;
    edges(2);
    rst_n = 1;
    edges(3);
    chk("R4 disarmed after reset", pwr_mode, 3);
    chk("R5 no battery unarmed", bat_sel, 0);

    finished = 1;
    $display("%0d/%0d checks passed", nchk - nfail, nchk);
    $finish;
  end

  initial begin
    #(200000 * 4);
    if (!finished) begin
      nchk++; nfail++;
      $display("FAIL watchdog actual=1 expected=0");
      $display("%0d/%0d checks passed", nchk - nfail, nchk);
      $finish;
    end
  end
endmodule